// File: doc/BRIEF.md
# Compressed Branch Trace Port Encoder

This block takes branch address events from a processor core and sends them off-chip on a narrow trace port. The port has four data lines, an active-low strobe that marks the start of each message, and a trace clock. Each event carries a 32-bit address and a flag that says whether it is a branch source or a branch destination. Each of these two streams keeps its own reference address. An address is sent only as the low part that differs from the last address sent on its stream: 4, 8, 16 or all 32 bits.

Events wait in a small queue before they are serialised. A mode input picks the response when the queue is full. In realtime mode the core is never held and trace may be lost. In that mode a second input picks whether a new event overwrites the oldest queued entry, or whether capture stops for good. In non-realtime mode the block raises a stall toward the core while the queue is full, and no event is lost. Both mode inputs are expected to be static while trace is running.

Top module: `trace_port_enc`

## Requirements
- R1: While reset is held and just after it is released, the strobe is high (inactive), the data lines are 0 and the stall output is low.
- R2: Every message starts with a header nibble. The strobe is low for that nibble only. Header bits [1:0] give the address length (0 = 4, 1 = 8, 2 = 16, 3 = 32 bits), bit 2 is the stream (1 = destination, 0 = source) and bit 3 is 0. The address nibbles follow, least significant nibble first.
- R3: The trace clock toggles every core clock cycle. Each nibble is presented for two cycles, first with the trace clock low and then high, and it does not change while the trace clock is high.
- R4: An address whose upper 28 bits equal those of its stream's reference is sent with length code 0, as one nibble.
- R5: Otherwise, an address whose upper 24 bits match is sent with length code 1, as two nibbles.
- R6: Otherwise, an address whose upper 16 bits match is sent with length code 2, as four nibbles.
- R7: Any other address is sent with length code 3, as eight nibbles. References reset to zero, so the first address of each stream after reset is usually sent in full.
- R8: The source and destination streams each compress against their own reference.
- R9: A reference takes a message's full address only when that message's last nibble has been sent. A queued message that starts right after it compresses against that just-finished address.
- R10: When the block is idle, the header of an accepted event appears on the port no later than two clock edges after the edge that accepted it.
- R11: In realtime mode the stall output stays low. With the overwrite policy, an event that meets a full queue replaces the oldest queued entry, so the newest event is always sent.
- R12: In realtime mode with the stop policy, an event that meets a full queue is discarded and capture stops until reset. Entries already queued are still sent.
- R13: In non-realtime mode, the stall output is high exactly while the queue is full. Events are accepted only while stall is low, and every event is sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid_i | input | 1 | Branch event present this cycle |
| evt_dest_i | input | 1 | 1 = branch destination stream, 0 = branch source stream |
| evt_addr_i | input | 32 | Branch address |
| realtime_i | input | 1 | 1 = never stall (trace may be lost), 0 = stall the core while the queue is full |
| fullstop_i | input | 1 | Realtime full-queue policy: 1 = stop capturing, 0 = overwrite the oldest entry |
| stall_o | output | 1 | Hold request toward the core |
| trc_clk_o | output | 1 | Trace clock; data is valid while it is high |
| trc_data_o | output | 4 | Trace data nibble |
| trc_sync_n_o | output | 1 | Active-low message start strobe |

## Verification
The queue registers an event on the edge that accepts it. The serialiser then loads the event at the next edge where the trace clock falls, so the header appears one or two edges later. The bench checks this bound by counting falling clock edges from the drive to the first low strobe. Each nibble is valid on the falling core-clock edge inside its trace-clock-high phase. The bench decodes the port only there, so its results do not depend on the phase the trace clock had when an event arrived. A reference update lands on the edge that ends a message's last nibble. Back-to-back bursts in stall mode show whether the next message saw that update on the same edge.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int ADDR_W = 32;
    localparam int NIB_W  = 4;
    localparam int MAX_NIB = ADDR_W / NIB_W;

    typedef enum logic [1:0] {
        LEN4  = 2'd0,
        LEN8  = 2'd1,
        LEN16 = 2'd2,
        LEN32 = 2'd3
    } len_e;

    typedef struct packed {
        logic              dest;
        logic [ADDR_W-1:0] addr;
    } evt_t;

    function automatic len_e pick_len(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] ref_a);
        if (a[ADDR_W-1:4] == ref_a[ADDR_W-1:4])       return LEN4;
        else if (a[ADDR_W-1:8] == ref_a[ADDR_W-1:8])  return LEN8;
        else if (a[ADDR_W-1:16] == ref_a[ADDR_W-1:16]) return LEN16;
        else                                           return LEN32;
    endfunction

    function automatic logic [3:0] nib_count(input len_e l);
        return 4'd1 << l;
    endfunction

    function automatic logic [NIB_W-1:0] header(input len_e l, input logic dest);
        return {1'b0, dest, l};
    endfunction

endpackage

// File: rtl/trace_evq.sv
module trace_evq
    import trc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  evt_t          din_i,
    input  logic          pop_i,
    input  logic          drop_i,
    output evt_t          head_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [CW-1:0] count_o
);

    evt_t          mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          adv_rd;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign adv_rd = pop_i | drop_i;

    always_ff @(posedge clk) begin
        if (push_i) mem[wr_q] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= wrap_inc(wr_q);
            if (adv_rd) rd_q <= wrap_inc(rd_q);
            cnt_q <= cnt_q + CW'(push_i) - CW'(adv_rd);
        end
    end

    assign head_o  = mem[rd_q];
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign count_o = cnt_q;

endmodule

// File: rtl/trace_delta.sv
module trace_delta
    import trc_pkg::*;
#(
    parameter int STREAMS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic              upd_dest_i,
    input  logic [ADDR_W-1:0] upd_addr_i,
    input  logic              qry_dest_i,
    input  logic [ADDR_W-1:0] qry_addr_i,
    output len_e              len_o
);

    logic [ADDR_W-1:0] ref_eff [STREAMS];

    for (genvar s = 0; s < STREAMS; s++) begin : g_stream
        logic [ADDR_W-1:0] ref_q;
        logic              hit;
        assign hit = upd_i && (upd_dest_i == s[0]);
        always_ff @(posedge clk) begin
            if (rst)      ref_q <= '0;
            else if (hit) ref_q <= upd_addr_i;
        end
        assign ref_eff[s] = hit ? upd_addr_i : ref_q;
    end

    assign len_o = pick_len(qry_addr_i, ref_eff[qry_dest_i]);

endmodule

// File: rtl/trace_serial.sv
module trace_serial
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              avail_i,
    input  evt_t              head_i,
    input  len_e              len_i,
    output logic              pop_o,
    output logic              done_o,
    output logic              done_dest_o,
    output logic [ADDR_W-1:0] done_addr_o,
    output logic              trc_clk_o,
    output logic [NIB_W-1:0]  data_o,
    output logic              sync_n_o
);

    logic              phase_q;
    logic              busy_q;
    logic [3:0]        rem_q;
    logic [ADDR_W-1:0] shift_q;
    evt_t              cur_q;
    logic [NIB_W-1:0]  data_q;
    logic              sync_n_q;
    logic              slot_end, advance, free;

    assign slot_end = phase_q;
    assign advance  = slot_end && busy_q && (rem_q != '0);
    assign free     = slot_end && (!busy_q || rem_q == '0);
    assign pop_o    = free && avail_i;
    assign done_o   = slot_end && busy_q && (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= 1'b0;
            busy_q   <= 1'b0;
            rem_q    <= '0;
            shift_q  <= '0;
            cur_q    <= '0;
            data_q   <= '0;
            sync_n_q <= 1'b1;
        end else begin
            phase_q <= ~phase_q;
            if (advance) begin
                data_q   <= shift_q[NIB_W-1:0];
                shift_q  <= shift_q >> NIB_W;
                rem_q    <= rem_q - 1'b1;
                sync_n_q <= 1'b1;
            end else if (pop_o) begin
                data_q   <= header(len_i, head_i.dest);
                sync_n_q <= 1'b0;
                shift_q  <= head_i.addr;
                rem_q    <= nib_count(len_i);
                cur_q    <= head_i;
                busy_q   <= 1'b1;
            end else if (free) begin
                data_q   <= '0;
                sync_n_q <= 1'b1;
                busy_q   <= 1'b0;
            end
        end
    end

    assign done_dest_o = cur_q.dest;
    assign done_addr_o = cur_q.addr;
    assign trc_clk_o   = phase_q;
    assign data_o      = data_q;
    assign sync_n_o    = sync_n_q;

endmodule

// File: rtl/trace_port_enc.sv
module trace_port_enc
    import trc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_valid_i,
    input  logic        evt_dest_i,
    input  logic [31:0] evt_addr_i,
    input  logic        realtime_i,
    input  logic        fullstop_i,
    output logic        stall_o,
    output logic        trc_clk_o,
    output logic [3:0]  trc_data_o,
    output logic        trc_sync_n_o
);

    evt_t              q_head, q_din;
    logic              q_empty, q_full, q_push, q_drop, q_pop;
    logic [CW-1:0]     q_count;
    logic              halted_q, set_halt;
    logic              upd;
    logic              upd_dest;
    logic [ADDR_W-1:0] upd_addr;
    len_e              head_len;

    assign q_din = '{dest: evt_dest_i, addr: evt_addr_i};

    always_comb begin
        q_push   = 1'b0;
        q_drop   = 1'b0;
        set_halt = 1'b0;
        if (evt_valid_i && !halted_q) begin
            if (!realtime_i) begin
                q_push = !q_full;
            end else if (!q_full || q_pop) begin
                q_push = 1'b1;
            end else if (!fullstop_i) begin
                q_push = 1'b1;
                q_drop = 1'b1;
            end else begin
                set_halt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           halted_q <= 1'b0;
        else if (set_halt) halted_q <= 1'b1;
    end

    assign stall_o = !realtime_i && q_full;

    trace_evq #(.DEPTH(DEPTH)) evq_i (
        .clk     (clk),
        .rst     (rst),
        .push_i  (q_push),
        .din_i   (q_din),
        .pop_i   (q_pop),
        .drop_i  (q_drop),
        .head_o  (q_head),
        .empty_o (q_empty),
        .full_o  (q_full),
        .count_o (q_count)
    );

    trace_delta #(.STREAMS(2)) delta_i (
        .clk        (clk),
        .rst        (rst),
        .upd_i      (upd),
        .upd_dest_i (upd_dest),
        .upd_addr_i (upd_addr),
        .qry_dest_i (q_head.dest),
        .qry_addr_i (q_head.addr),
        .len_o      (head_len)
    );

    trace_serial ser_i (
        .clk         (clk),
        .rst         (rst),
        .avail_i     (!q_empty),
        .head_i      (q_head),
        .len_i       (head_len),
        .pop_o       (q_pop),
        .done_o      (upd),
        .done_dest_o (upd_dest),
        .done_addr_o (upd_addr),
        .trc_clk_o   (trc_clk_o),
        .data_o      (trc_data_o),
        .sync_n_o    (trc_sync_n_o)
    );

endmodule

// File: rtl/trace_port_enc_chk.sv
module trace_port_enc_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          realtime_i,
    input logic          fullstop_i,
    input logic          evt_valid_i,
    input logic          stall_o,
    input logic          trc_clk_o,
    input logic [3:0]    trc_data_o,
    input logic          trc_sync_n_o,
    input logic          q_full,
    input logic          q_pop,
    input logic [CW-1:0] q_count,
    input logic          halted_q
);

    assert_no_stall_rt_R11: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> !realtime_i);

    assert_overwrite_keeps_full_R11: assert property (@(posedge clk) disable iff (rst)
        (realtime_i && !fullstop_i && q_full && evt_valid_i && !q_pop && !halted_q) |=> q_full);

    assert_sync_one_nibble_R2: assert property (@(posedge clk) disable iff (rst)
        (!trc_sync_n_o && trc_clk_o) |=> trc_sync_n_o);

    assert_sync_two_cycles_R2: assert property (@(posedge clk) disable iff (rst)
        (!trc_sync_n_o && !trc_clk_o) |=> !trc_sync_n_o);

    assert_clk_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        trc_clk_o |=> !trc_clk_o);

    assert_hold_high_R3: assert property (@(posedge clk) disable iff (rst)
        trc_clk_o |-> ($stable(trc_data_o) && $stable(trc_sync_n_o)));

    assert_stall_no_growth_R13: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (q_count <= $past(q_count)));

    assert_halt_no_growth_R12: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> (q_count <= $past(q_count)));

endmodule

bind trace_port_enc trace_port_enc_chk #(.CW(CW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .realtime_i   (realtime_i),
    .fullstop_i   (fullstop_i),
    .evt_valid_i  (evt_valid_i),
    .stall_o      (stall_o),
    .trc_clk_o    (trc_clk_o),
    .trc_data_o   (trc_data_o),
    .trc_sync_n_o (trc_sync_n_o),
    .q_full       (q_full),
    .q_pop        (q_pop),
    .q_count      (q_count),
    .halted_q     (halted_q)
);

// File: tb/trace_port_enc_tb_top.sv
module trace_port_enc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid_i = 1'b0;
    logic        evt_dest_i = 1'b0;
    logic [31:0] evt_addr_i = '0;
    logic        realtime_i = 1'b1;
    logic        fullstop_i = 1'b0;
    logic        stall_o, trc_clk_o, trc_sync_n_o;
    logic [3:0]  trc_data_o;

    always #5 clk = ~clk;

    trace_port_enc dut_i (
        .clk          (clk),
        .rst          (rst),
        .evt_valid_i  (evt_valid_i),
        .evt_dest_i   (evt_dest_i),
        .evt_addr_i   (evt_addr_i),
        .realtime_i   (realtime_i),
        .fullstop_i   (fullstop_i),
        .stall_o      (stall_o),
        .trc_clk_o    (trc_clk_o),
        .trc_data_o   (trc_data_o),
        .trc_sync_n_o (trc_sync_n_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Port decoder built from R2/R4..R7: header, then LSN-first address nibbles.
    int          msg_count = 0;
    logic [31:0] got_addr [64];
    logic [1:0]  got_code [64];
    logic        got_dest [64];
    logic [31:0] dref [2];
    bit          in_msg = 1'b0;
    int          m_need, m_got;
    logic [1:0]  m_code;
    logic        m_dest;
    logic [31:0] m_acc;
    int          sync_err = 0;

    always @(negedge clk) begin
        if (!rst && trc_clk_o) begin
            if (!trc_sync_n_o) begin
                if (in_msg) sync_err++;
                in_msg = 1'b1;
                m_code = trc_data_o[1:0];
                m_dest = trc_data_o[2];
                m_need = 1 << trc_data_o[1:0];
                m_got  = 0;
                m_acc  = '0;
            end else if (in_msg) begin
                logic [31:0] mask, full_a;
                m_acc = m_acc | (32'(trc_data_o) << (4 * m_got));
                m_got++;
                if (m_got == m_need) begin
                    mask   = (m_need == 8) ? 32'hFFFF_FFFF : ((32'h1 << (4 * m_need)) - 32'h1);
                    full_a = (dref[m_dest] & ~mask) | (m_acc & mask);
                    dref[m_dest] = full_a;
                    got_addr[msg_count % 64] = full_a;
                    got_code[msg_count % 64] = m_code;
                    got_dest[msg_count % 64] = m_dest;
                    msg_count++;
                    in_msg = 1'b0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic do_reset(input bit rt, input bit stop);
        @(negedge clk);
        rst = 1'b1;
        evt_valid_i = 1'b0;
        realtime_i = rt;
        fullstop_i = stop;
        repeat (3) @(negedge clk);
        msg_count = 0;
        in_msg = 1'b0;
        dref[0] = '0;
        dref[1] = '0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_msgs(input int n);
        for (int k = 0; k < 400 && msg_count < n; k++) @(negedge clk);
    endtask

    // {dest, expected length code, address}
    localparam logic [34:0] VEC [10] = '{
        {1'b0, 2'd3, 32'h1234_5678},
        {1'b0, 2'd0, 32'h1234_567A},
        {1'b0, 2'd1, 32'h1234_56F0},
        {1'b0, 2'd2, 32'h1234_9ABC},
        {1'b0, 2'd3, 32'h8765_9ABC},
        {1'b1, 2'd3, 32'h8765_9ABD},
        {1'b1, 2'd0, 32'h8765_9ABD},
        {1'b0, 2'd0, 32'h8765_9ABF},
        {1'b1, 2'd3, 32'h0000_0010},
        {1'b0, 2'd2, 32'h8765_0000}
    };

    localparam logic [31:0] BASE = 32'h4000_0000;

    initial begin
        dref[0] = '0;
        dref[1] = '0;
        // R1: reset state
        repeat (2) @(negedge clk);
        check(trc_sync_n_o == 1'b1, "R1 sync idle in reset", 32'(trc_sync_n_o), 1);
        check(trc_data_o == 4'h0, "R1 data zero in reset", 32'(trc_data_o), 0);
        do_reset(1'b1, 1'b0);
        check(trc_sync_n_o == 1'b1 && trc_data_o == 4'h0, "R1 idle after reset",
              {27'd0, trc_sync_n_o, trc_data_o}, 32'h10);
        check(stall_o == 1'b0, "R1 no stall after reset", 32'(stall_o), 0);

        // Vector table: R2, R4..R8, R10
        for (int i = 0; i < 10; i++) begin
            int lat;
            evt_dest_i  = VEC[i][34];
            evt_addr_i  = VEC[i][31:0];
            evt_valid_i = 1'b1;
            @(negedge clk);
            evt_valid_i = 1'b0;
            lat = 1;
            while (trc_sync_n_o && lat < 10) begin
                @(negedge clk);
                lat++;
            end
            check(lat <= 3, "R10 header latency", 32'(lat), 3);
            wait_msgs(i + 1);
            check(got_code[i] == VEC[i][33:32], "R4/R5/R6/R7 length code",
                  32'(got_code[i]), 32'(VEC[i][33:32]));
            check(got_addr[i] == VEC[i][31:0] && got_dest[i] == VEC[i][34],
                  "R2/R8 decoded address and stream", got_addr[i], VEC[i][31:0]);
            repeat (4) @(negedge clk);
        end
        check(sync_err == 0, "R2 strobe only on header", 32'(sync_err), 0);

        // R11: realtime overwrite burst
        do_reset(1'b1, 1'b0);
        begin
            int stalls = 0;
            for (int i = 0; i < 8; i++) begin
                evt_dest_i  = 1'b0;
                evt_addr_i  = BASE | 32'(i);
                evt_valid_i = 1'b1;
                @(negedge clk);
                if (stall_o) stalls++;
            end
            evt_valid_i = 1'b0;
            repeat (150) @(negedge clk);
            check(stalls == 0, "R11 no stall in realtime", 32'(stalls), 0);
            check(msg_count < 8 && msg_count > 1, "R11 some events lost", 32'(msg_count), 7);
            check(got_addr[(msg_count + 63) % 64] == (BASE | 32'd7), "R11 newest event kept",
                  got_addr[(msg_count + 63) % 64], BASE | 32'd7);
            check(got_addr[0] == BASE, "R11 first event sent", got_addr[0], BASE);
        end

        // R12: realtime stop policy
        do_reset(1'b1, 1'b1);
        begin
            int n_before;
            for (int i = 0; i < 8; i++) begin
                evt_dest_i  = 1'b0;
                evt_addr_i  = BASE | 32'(i);
                evt_valid_i = 1'b1;
                @(negedge clk);
            end
            evt_valid_i = 1'b0;
            repeat (150) @(negedge clk);
            n_before = msg_count;
            check(n_before < 8 && got_addr[(n_before + 63) % 64] != (BASE | 32'd7),
                  "R12 late event discarded", got_addr[(n_before + 63) % 64], 32'hFFFF_FFFF);
            evt_addr_i  = 32'h5000_0000;
            evt_valid_i = 1'b1;
            @(negedge clk);
            evt_valid_i = 1'b0;
            repeat (100) @(negedge clk);
            check(msg_count == n_before, "R12 capture stays stopped", 32'(msg_count), 32'(n_before));
        end

        // R13 / R9: non-realtime stall burst
        do_reset(1'b0, 1'b0);
        begin
            bit saw_stall = 1'b0;
            int code_bad = 0;
            int addr_bad = 0;
            for (int i = 0; i < 8; i++) begin
                evt_dest_i  = 1'b0;
                evt_addr_i  = BASE | 32'(i);
                evt_valid_i = 1'b1;
                while (stall_o) begin
                    saw_stall = 1'b1;
                    @(negedge clk);
                end
                @(negedge clk);
            end
            evt_valid_i = 1'b0;
            wait_msgs(8);
            for (int i = 0; i < 8; i++) begin
                if (got_addr[i] != (BASE | 32'(i))) addr_bad++;
                if (i > 0 && got_code[i] != 2'd0) code_bad++;
            end
            check(saw_stall, "R13 stall raised on full queue", 32'(saw_stall), 1);
            check(msg_count == 8 && addr_bad == 0, "R13 all events in order", 32'(addr_bad), 0);
            check(got_code[0] == 2'd3, "R7 first after reset full", 32'(got_code[0]), 3);
            check(code_bad == 0, "R9 back-to-back uses just-sent reference", 32'(code_bad), 0);
            repeat (4) @(negedge clk);
            check(stall_o == 1'b0, "R13 stall released when drained", 32'(stall_o), 0);
        end

        // R3: clock toggles and data holds through high phase
        begin
            int bad = 0;
            logic pc;
            logic [3:0] pd;
            pc = trc_clk_o;
            pd = trc_data_o;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (trc_clk_o == pc) bad++;
                if (trc_clk_o && trc_data_o != pd) bad++;
                pc = trc_clk_o;
                pd = trc_data_o;
            end
            check(bad == 0, "R3 trace clock toggles, data held", 32'(bad), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule